// File: doc/BRIEF.md
# Hashing Chip Command Frame Decoder

This block sits behind the receive side of a hashing chip's serial command link. It counts incoming bytes into frames of exactly 112 bytes. When the last byte of a frame arrives, it looks at that byte to decide what kind of frame it was and applies the frame in the same clock edge.

There are three frame kinds:
- A global frame loads an eight-byte configuration word. Byte 1 of that word drives a diagnostic-mode enable and two clock-generator control bits.
- A cluster frame loads one of six per-cluster registers: a 16-bit core-enable mask and a 32-bit nonce start offset.
- Any other frame is a work frame. It is sent in fully reversed byte order. The decoder undoes the reversal and presents the 80-byte block header and the 8 target bytes with a one-cycle load strobe.

A realign input lets the link controller force the decoder back to the start of a frame after a framing loss.

Top module: `hash_cmd_frame_rx`

## Requirements
- R1: After reset, the global word reads bytes 0..7 = 00 04 40 00 00 00 00 01, with byte n at bits [8n+7:8n]. All cluster masks and offsets are zero and no strobe is high.
- R2: A frame is 112 accepted bytes, numbered 0..111 in arrival order. The update and its strobe appear in the cycle after byte 111 is accepted, and never earlier.
- R3: If byte 111 is 0xFF, arrival bytes 102..109 become global bytes 0..7 and `glob_stb_o` pulses for one cycle.
- R4: If byte 111 is 0xFE, byte 110 selects a cluster. Bytes 104..105 (most significant first) become that cluster's mask and bytes 106..109 (most significant first) become its offset. `clus_stb_o` pulses, and no other cluster changes. Cluster c's mask is at `core_mask_o[16c+15:16c]` and its offset at `nonce_off_o[32c+31:32c]`.
- R5: A cluster frame whose index byte is 6 or more changes no register and raises no strobe.
- R6: Any frame whose byte 111 is neither 0xFF nor 0xFE is a work frame. Header byte h (0..79) is arrival byte 79-h, and target byte t (0..7) is arrival byte 87-t. Header byte h appears at `work_hdr_o[8h+7:8h]`, target byte t at `work_target_o[8t+7:8t]`, and `work_stb_o` pulses.
- R7: `diag_en_o` follows bit 0 of global byte 1, and `pll_ctl_o` follows bits 3:2 of global byte 1.
- R8: While `realign_i` is high, the byte counter returns to 0 and any byte offered in that cycle is dropped. The next accepted byte is byte 0.
- R9: Cycles with `rx_valid_i` low do not advance the framing.
- R10: Each completed frame raises at most one strobe. A global or work frame raises exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| realign_i | input | 1 | Restart framing at byte 0 |
| rx_valid_i | input | 1 | A received byte is present |
| rx_data_i | input | 8 | Received byte |
| glob_reg_o | output | 64 | Global configuration word |
| diag_en_o | output | 1 | Diagnostic mode enable |
| pll_ctl_o | output | 2 | Clock generator control bits |
| core_mask_o | output | 16*NCL | Per-cluster core-enable masks |
| nonce_off_o | output | 32*NCL | Per-cluster nonce start offsets |
| glob_stb_o | output | 1 | Global word updated |
| clus_stb_o | output | 1 | A cluster register updated |
| work_stb_o | output | 1 | New work loaded |
| work_hdr_o | output | 640 | Block header, byte h at [8h+7:8h] |
| work_target_o | output | 64 | Target bytes, byte t at [8t+7:8t] |

## Verification
The bench sweeps every cluster index from 0 to 7. An off-by-one range check would either write past the last cluster or drop cluster 5. A decoder that ignored the index would corrupt a neighbour.

Work frames are checked byte by byte against the reversed layout. This catches a design that forgot the reversal or skewed the target window. One work frame ends in an unusual trailer byte to catch decoders that only accept a zero trailer.

Bytes are fed with idle gaps, and a realign is issued mid-frame on a cycle that also offers a byte. A counter that advanced on idle cycles, or kept that dropped byte, would strobe at the wrong time or load shifted fields.

// File: rtl/hash_cmd_frame_rx.sv
module hash_cmd_frame_rx #(
  parameter int NCL = 6,
  parameter logic [7:0] OP_GLOB = 8'hFF,
  parameter logic [7:0] OP_CLUS = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              realign_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic [63:0]       glob_reg_o,
  output logic              diag_en_o,
  output logic [1:0]        pll_ctl_o,
  output logic [16*NCL-1:0] core_mask_o,
  output logic [32*NCL-1:0] nonce_off_o,
  output logic              glob_stb_o,
  output logic              clus_stb_o,
  output logic              work_stb_o,
  output logic [639:0]      work_hdr_o,
  output logic [63:0]       work_target_o
);
  localparam int FB  = 112;
  localparam int CW  = $clog2(FB);
  localparam int HB  = 80;
  localparam int TB  = 8;
  localparam logic [63:0] GLOB_RST = 64'h0100_0000_0040_0400;

  logic [CW-1:0]   cnt;
  logic [FB*8-1:0] sr;
  logic [FB*8-1:0] nxt;
  logic [7:0]      fb [FB];

  wire take = rx_valid_i && !realign_i;
  wire last = take && (cnt == CW'(FB - 1));

  assign nxt = {sr[FB*8-9:0], rx_data_i};

  always_comb
    for (int k = 0; k < FB; k++) fb[k] = nxt[8*(FB-1-k) +: 8];

  wire [7:0]  op     = fb[111];
  wire [7:0]  idx    = fb[110];
  wire        is_glb = last && op == OP_GLOB;
  wire        is_cls = last && op == OP_CLUS;
  wire        is_wrk = last && op != OP_GLOB && op != OP_CLUS;
  wire        idx_ok = idx < 8'(NCL);
  wire [15:0] mask_n = {fb[104], fb[105]};
  wire [31:0] off_n  = {fb[106], fb[107], fb[108], fb[109]};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (realign_i) cnt <= '0;
    else if (rx_valid_i) cnt <= last ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else if (take) sr <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_reg_o <= GLOB_RST;
      glob_stb_o <= 1'b0;
      clus_stb_o <= 1'b0;
      work_stb_o <= 1'b0;
    end else begin
      glob_stb_o <= is_glb;
      clus_stb_o <= is_cls && idx_ok;
      work_stb_o <= is_wrk;
      if (is_glb)
        for (int n = 0; n < 8; n++) glob_reg_o[8*n +: 8] <= fb[102+n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_hdr_o    <= '0;
      work_target_o <= '0;
    end else if (is_wrk) begin
      for (int h = 0; h < HB; h++) work_hdr_o[8*h +: 8] <= fb[HB-1-h];
      for (int t = 0; t < TB; t++) work_target_o[8*t +: 8] <= fb[HB+TB-1-t];
    end
  end

  for (genvar c = 0; c < NCL; c++) begin : g_clus
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        core_mask_o[16*c +: 16] <= '0;
        nonce_off_o[32*c +: 32] <= '0;
      end else if (is_cls && idx == 8'(c)) begin
        core_mask_o[16*c +: 16] <= mask_n;
        nonce_off_o[32*c +: 32] <= off_n;
      end
    end
  end

  assign diag_en_o = glob_reg_o[8];
  assign pll_ctl_o = glob_reg_o[11:10];

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({glob_stb_o, clus_stb_o, work_stb_o}));
  assert_stb_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_stb_o || clus_stb_o || work_stb_o) |-> $past(rx_valid_i && !realign_i));
  assert_glob_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_stb_o |-> $stable(glob_reg_o));
  assert_clus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clus_stb_o |-> ($stable(core_mask_o) && $stable(nonce_off_o)));
  assert_work_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !work_stb_o |-> $stable(work_hdr_o));
  assert_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    realign_i |=> cnt == '0);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid_i && !realign_i) |=> $stable(cnt));
endmodule

// File: tb/hash_cmd_frame_rx_tb.sv
`timescale 1ns/1ps
module hash_cmd_frame_rx_tb_top;
  localparam int NCL = 6;
  logic clk = 0, rst_n = 0, realign = 0, rxv = 0;
  logic [7:0] rxd = 0;
  logic [63:0] glob;
  logic diag;
  logic [1:0] pll;
  logic [16*NCL-1:0] mask;
  logic [32*NCL-1:0] off;
  logic gstb, cstb, wstb;
  logic [639:0] hdr;
  logic [63:0] tgt;

  hash_cmd_frame_rx #(.NCL(NCL)) dut_i (
    .clk(clk), .rst_n(rst_n), .realign_i(realign), .rx_valid_i(rxv), .rx_data_i(rxd),
    .glob_reg_o(glob), .diag_en_o(diag), .pll_ctl_o(pll), .core_mask_o(mask),
    .nonce_off_o(off), .glob_stb_o(gstb), .clus_stb_o(cstb), .work_stb_o(wstb),
    .work_hdr_o(hdr), .work_target_o(tgt));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, stb_total = 0, exp_stb = 0;
  logic [7:0] fr [112];
  logic [7:0] wb [112];
  logic [63:0] e_glob;
  logic [15:0] e_mask [NCL];
  logic [31:0] e_off [NCL];

  always @(negedge clk) if (rst_n) stb_total += int'(gstb) + int'(cstb) + int'(wstb);

  task automatic chk(input string req, input logic [639:0] act, input logic [639:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int gap);
    for (int k = 0; k < 112; k++) begin
      @(negedge clk); rxv = 1; rxd = fr[k];
      if (k < 111)
        for (int g = 0; g < gap; g++) begin @(negedge clk); rxv = 0; end
    end
    @(negedge clk); rxv = 0;
  endtask

  task automatic chk_regs(input string req);
    logic [16*NCL-1:0] m; logic [32*NCL-1:0] o;
    for (int c = 0; c < NCL; c++) begin m[16*c +: 16] = e_mask[c]; o[32*c +: 32] = e_off[c]; end
    chk(req, glob, e_glob);
    chk(req, mask, m);
    chk(req, off, o);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    e_glob = 64'h0100_0000_0040_0400;
    for (int c = 0; c < NCL; c++) begin e_mask[c] = 0; e_off[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", glob, 64'h0100_0000_0040_0400);
    chk("R1", {gstb, cstb, wstb}, 0);
    chk("R1", {diag, pll}, 3'b001);
    chk_regs("R1");

    // R3 R7 R9 global writes with gaps
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 112; k++) fr[k] = 8'(k ^ 8'h5A);
      for (int n = 0; n < 8; n++) begin
        fr[102+n] = 8'(n * 29 + p * 71 + 3);
        e_glob[8*n +: 8] = fr[102+n];
      end
      fr[111] = 8'hFF;
      send(p);
      exp_stb++;
      chk("R3", gstb, 1);
      chk("R2", {cstb, wstb}, 0);
      chk_regs("R3");
      chk("R7", diag, e_glob[8]);
      chk("R7", pll, e_glob[11:10]);
      @(negedge clk);
      chk("R2", gstb, 0);
    end

    // R4 R5 cluster sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] m; logic [31:0] o;
      m = 16'(i * 16'h1234 + 16'h0101);
      o = 32'(i) * 32'h2AAA_AAAB + 32'h11;
      for (int k = 0; k < 112; k++) fr[k] = 8'(k + i);
      fr[104] = m[15:8]; fr[105] = m[7:0];
      fr[106] = o[31:24]; fr[107] = o[23:16]; fr[108] = o[15:8]; fr[109] = o[7:0];
      fr[110] = 8'(i); fr[111] = 8'hFE;
      send(i % 2);
      if (i < NCL) begin
        e_mask[i] = m; e_off[i] = o; exp_stb++;
        chk("R4", cstb, 1);
        chk_regs("R4");
      end else begin
        chk("R5", cstb, 0);
        chk_regs("R5");
      end
    end

    // R6 work frames, byte-reversed
    for (int s = 0; s < 3; s++) begin
      logic [639:0] eh; logic [63:0] et;
      for (int j = 0; j < 24; j++) wb[j] = 0;
      if (s == 2) wb[0] = 8'h37;
      for (int t = 0; t < 8; t++) begin wb[24+t] = 8'(t * 13 + s * 5 + 1); et[8*t +: 8] = wb[24+t]; end
      for (int h = 0; h < 80; h++) begin wb[32+h] = 8'(h * 3 + s * 41); eh[8*h +: 8] = wb[32+h]; end
      for (int k = 0; k < 112; k++) fr[k] = wb[111-k];
      send(s);
      exp_stb++;
      chk("R6", wstb, 1);
      chk("R6", hdr, eh);
      chk("R6", tgt, et);
      chk_regs("R6");
    end

    // R8 realign mid-frame, with a byte offered in the realign cycle
    for (int k = 0; k < 37; k++) begin @(negedge clk); rxv = 1; rxd = 8'hFF; end
    @(negedge clk); realign = 1; rxv = 1; rxd = 8'hFF;
    @(negedge clk); realign = 0; rxv = 0;
    chk("R8", {gstb, cstb, wstb}, 0);
    for (int k = 0; k < 112; k++) fr[k] = 8'hFF;
    for (int n = 0; n < 8; n++) begin fr[102+n] = 8'(8'hA0 + n); e_glob[8*n +: 8] = fr[102+n]; end
    send(0);
    exp_stb++;
    chk("R8", gstb, 1);
    chk_regs("R8");

    repeat (3) @(negedge clk);
    chk("R10", stb_total, exp_stb);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule